// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block is a read-only serial master for a 12-bit successive-approximation converter that returns 16-bit frames. It drives an active-low chip select (`cs_n`) and a serial clock (`sclk`) derived from the system clock by division, and samples the converter's data line (`sdata`). Each frame holds three leading zero bits, then the twelve result bits from most to least significant, then one trailing bit. The block writes the 12-bit result through a simple address-plus-data write port into an external sample memory. If a frame's leading bits are not all zero, it raises a sticky error flag.

A capture starts with a one-cycle `start` pulse and a sample `count`. A count of 1 takes a single conversion, and a larger count takes a burst. Each sample in a burst is a separate framed transfer. After `enable` rises, the block waits a settling time, then runs one dummy conversion to flush stale data, and only after that raises `ready`.

The controller is a single state machine. Its states are OFF (disabled), SETTLE (power-up wait), IDLE (ready), SETUP (chip select low, clock high), LOW and HIGH (the two halves of each serial clock) and GAP (chip select high between frames). Its transitions are:
- OFF to SETTLE when enable rises.
- SETTLE to SETUP after the settle count.
- IDLE to SETUP on an accepted start.
- SETUP to LOW, and LOW to HIGH, each after one half period.
- HIGH to LOW for the next bit, or HIGH to GAP after the 16th bit.
- GAP to SETUP for the next sample, or GAP to IDLE after the dummy frame or the last sample.
- Any state to OFF when enable falls.

Top module: `adc_frame_capture`

## Requirements
- R1: A synchronous active-high reset leaves `cs_n` and `sclk` high, and leaves `busy`, `done`, `ready`, `req_err`, `frame_err` and `wr_en` low.
- R2: Every frame has the same fixed timing, with H = HALF_DIV system cycles:
  - `cs_n` goes low while `sclk` stays high for H cycles.
  - 16 serial clocks follow, each H cycles low and then H cycles high.
  - `cs_n` returns high in the cycle after the 16th high phase and stays high for at least 2H cycles.
  - `sclk` is never low while `cs_n` is high.
- R3: `sdata` is captured on each rising edge of `sclk`, most significant bit first. The value written is frame bits 12 to 1, which equals (frame >> 1) & 0xFFF. Frame bit 0 has no effect on the value.
- R4: If any of frame bits 15 to 13 is 1, `frame_err` rises in the same cycle as that frame's write, and the value is still written. `frame_err` stays high until reset. Neither disable nor later good frames clear it.
- R5: When `enable` rises, the block waits SETTLE_CYC cycles and then runs one dummy frame with the R2 timing. The dummy frame makes no write and is not checked against R4. `ready` rises in the cycle after that frame's gap ends. Any `start` before then is ignored.
- R6: For an accepted count N, the block produces N separate frames. The result of sample i is written with `wr_addr` = i, and `wr_en` is high for exactly one cycle: the first gap cycle of that frame.
- R7: A `start` with `count` equal to 0 or greater than MAX_SAMPLES is rejected. `req_err` pulses for one cycle, in the cycle after the start. No frame begins and `busy` stays low.
- R8: `busy` is high from the cycle after an accepted start through the last gap cycle. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: A `start` that arrives while `busy` is high is ignored. No extra frame, write or reject follows from it.
- R10: If `enable` falls during a capture, the block is in OFF in the next cycle: `cs_n` and `sclk` are high, and `busy` and `ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; a rising edge starts settle and the dummy conversion |
| start | input | 1 | One-cycle capture request |
| count | input | CNT_W | Number of samples for the request |
| busy | output | 1 | Capture in progress |
| done | output | 1 | One-cycle end-of-capture pulse |
| ready | output | 1 | Initial dummy conversion finished |
| req_err | output | 1 | One-cycle pulse when a request is rejected |
| frame_err | output | 1 | Sticky bad-leading-bits flag |
| wr_en | output | 1 | Sample memory write strobe |
| wr_addr | output | ADDR_W | Sample memory address |
| wr_data | output | 12 | Extracted 12-bit result |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata | input | 1 | Serial data from the converter |

## Verification
The bench models the converter behaviourally, and each frame it serves is chosen to separate one kind of fault:
- All-ones data, 0x1FFF, catches lost or stuck data bits.
- A frame with only bit 0 set must read back as 0, which exposes an off-by-one in the bit extraction.
- Single set bits at the data MSB and LSB, 0x1000 and 0x0002, expose shift-direction and alignment errors.
- A frame with a set leading bit, inside a maximum-length burst, shows that the error flag is sticky and that the value is still delivered.
- A bad word served in the dummy frame shows that dummy results are discarded.

Reject counts of 0, MAX+1 and the largest value the count field can carry distinguish a correct range check from one that tests only a single bound. Starts issued before `ready` and while `busy` show that no extra frame or write follows from them. An abort in mid-frame shows that chip select and the clock return to idle at once.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int LEAD_BITS  = 3;
    // bits kept from a frame: everything except the trailing bit
    localparam int KEEP_BITS  = FRAME_BITS - 1;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } cap_state_t;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic long_phase,
    output logic tick
);
    localparam int HW = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [HW-1:0] LIM_SHORT = HW'(HALF_DIV - 1);
    localparam logic [HW-1:0] LIM_LONG  = HW'(2 * HALF_DIV - 1);

    logic [HW-1:0] hcnt;

    assign tick = run && (hcnt == (long_phase ? LIM_LONG : LIM_SHORT));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter
    import adc_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_en,
    input  logic                 sdata_in,
    output logic [DATA_BITS-1:0] result,
    output logic                 lead_bad
);
    // Holds frame bits 15..1; the trailing bit is never shifted in.
    logic [KEEP_BITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (sample_en) begin
            sh <= {sh[KEEP_BITS-2:0], sdata_in};
        end
    end

    assign result   = sh[DATA_BITS-1:0];
    assign lead_bad = |sh[KEEP_BITS-1:DATA_BITS];

endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture
    import adc_cap_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SETTLE_CYC  = 16,
    parameter int MAX_SAMPLES = 64,
    localparam int CNT_W  = $clog2(MAX_SAMPLES + 1) + 1,
    localparam int ADDR_W = (MAX_SAMPLES > 1) ? $clog2(MAX_SAMPLES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 start,
    input  logic [CNT_W-1:0]     count,
    output logic                 busy,
    output logic                 done,
    output logic                 ready,
    output logic                 req_err,
    output logic                 frame_err,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [DATA_BITS-1:0] wr_data,
    output logic                 cs_n,
    output logic                 sclk,
    input  logic                 sdata
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [BW-1:0]    LAST_BIT    = BW'(FRAME_BITS - 1);
    localparam logic [SW-1:0]    SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX     = CNT_W'(MAX_SAMPLES);
    localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

    cap_state_t state, state_nx;

    logic [BW-1:0]        bit_cnt;
    logic [SW-1:0]        settle_cnt;
    logic [CNT_W-1:0]     left;
    logic [ADDR_W-1:0]    addr;
    logic                 dummy;
    logic                 tick;
    logic                 run;
    logic                 start_ok;
    logic [DATA_BITS-1:0] sh_result;
    logic                 sh_lead_bad;

    assign start_ok = start && (count != '0) && (count <= CNT_MAX);
    assign run      = state inside {ST_SETUP, ST_LOW, ST_HIGH, ST_GAP};

    adc_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .long_phase (state == ST_GAP),
        .tick       (tick)
    );

    // capture only on LOW->HIGH, and never the trailing bit
    adc_frame_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sample_en (state == ST_LOW && tick && bit_cnt != LAST_BIT),
        .sdata_in  (sdata),
        .result    (sh_result),
        .lead_bad  (sh_lead_bad)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:    if (enable) state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_cnt == SETTLE_LAST) state_nx = ST_SETUP;
            ST_IDLE:   if (start_ok) state_nx = ST_SETUP;
            ST_SETUP:  if (tick) state_nx = ST_LOW;
            ST_LOW:    if (tick) state_nx = ST_HIGH;
            ST_HIGH:   if (tick) state_nx = (bit_cnt == LAST_BIT) ? ST_GAP : ST_LOW;
            ST_GAP:    if (tick) state_nx = (dummy || left == CNT_ONE) ? ST_IDLE : ST_SETUP;
            default:   state_nx = ST_OFF;
        endcase
        if (!enable) state_nx = ST_OFF;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nx;
    end

    // datapath and flag registers
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            settle_cnt <= '0;
            left       <= '0;
            addr       <= '0;
            dummy      <= 1'b0;
            ready      <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            done       <= 1'b0;
            req_err    <= 1'b0;
            frame_err  <= 1'b0;
        end else if (!enable) begin
            bit_cnt    <= '0;
            settle_cnt <= '0;
            dummy      <= 1'b0;
            ready      <= 1'b0;
            wr_en      <= 1'b0;
            done       <= 1'b0;
            req_err    <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            done    <= 1'b0;
            req_err <= 1'b0;
            unique case (state)
                ST_OFF: begin
                    settle_cnt <= '0;
                    dummy      <= 1'b1;
                    bit_cnt    <= '0;
                end
                ST_SETTLE: settle_cnt <= settle_cnt + 1'b1;
                ST_IDLE: begin
                    if (start) begin
                        if (start_ok) begin
                            left    <= count;
                            addr    <= '0;
                            bit_cnt <= '0;
                        end else begin
                            req_err <= 1'b1;
                        end
                    end
                end
                ST_SETUP, ST_LOW: ;
                ST_HIGH: begin
                    if (tick) begin
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            if (!dummy) begin
                                wr_en     <= 1'b1;
                                wr_addr   <= addr;
                                wr_data   <= sh_result;
                                addr      <= addr + 1'b1;
                                frame_err <= frame_err | sh_lead_bad;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (dummy) begin
                            dummy <= 1'b0;
                            ready <= 1'b1;
                        end else begin
                            left <= left - 1'b1;
                            if (left == CNT_ONE) done <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // pin and status outputs
    always_comb begin
        cs_n = 1'b1;
        sclk = 1'b1;
        busy = 1'b0;
        unique case (state)
            ST_SETUP, ST_HIGH: cs_n = 1'b0;
            ST_LOW: begin
                cs_n = 1'b0;
                sclk = 1'b0;
            end
            default: ;
        endcase
        if (run && !dummy) busy = 1'b1;
    end

    AST_SCLK_IDLE_WITH_CS: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk); // R2
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err); // R4
    AST_BUSY_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        busy |-> ready); // R5
    AST_WRITE_IN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (busy && cs_n)); // R6
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (cs_n && !busy)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R8
    AST_BUSY_START_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !req_err); // R9
    AST_DISABLE_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cs_n && sclk && !ready)); // R10

endmodule

// File: tb/adc_frame_capture_test.sv
module adc_frame_capture_test;
    localparam int H      = 4;
    localparam int SETTLE = 8;
    localparam int MAXS   = 8;
    localparam int CW     = $clog2(MAXS + 1) + 1;
    localparam int AW     = $clog2(MAXS);

    typedef struct packed {
        logic          cs_n, sclk, busy, done, wr_en, req_err, ready, ferr;
        logic [AW-1:0] addr;
        logic [11:0]   data;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1, enable = 1'b0, start = 1'b0, sdata = 1'b0;
    logic [CW-1:0] count = '0;
    logic busy, done, ready, req_err, frame_err, wr_en, cs_n, sclk;
    logic [AW-1:0] wr_addr;
    logic [11:0]   wr_data;

    exp_t q[$];
    exp_t last;
    logic [15:0] adc_q[$];
    logic [15:0] words_q[$];
    logic [15:0] cur = '0;
    int idx = 0;
    bit chk_on = 1'b0, fe_push = 1'b0, finished = 1'b0;
    int n_vec = 0, n_bad = 0, wr_seen = 0;

    always #5 clk = ~clk;

    adc_frame_capture #(.HALF_DIV(H), .SETTLE_CYC(SETTLE), .MAX_SAMPLES(MAXS)) uut (
        .clk(clk), .rst(rst), .enable(enable), .start(start), .count(count),
        .busy(busy), .done(done), .ready(ready), .req_err(req_err),
        .frame_err(frame_err), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cs_n(cs_n), .sclk(sclk), .sdata(sdata));

    // converter model: load a word when chip select falls, shift out on falling sclk
    always @(negedge cs_n or negedge sclk) begin
        if (sclk) begin
            cur = (adc_q.size() > 0) ? adc_q.pop_front() : 16'h0000;
            idx = 15;
        end else if (idx >= 0) begin
            sdata <= cur[idx];
            idx = idx - 1;
        end
    end

    function automatic exp_t mk(bit c, bit s, bit b, bit d, bit w, bit r, bit rd,
                                bit f, int a, logic [11:0] dt);
        exp_t e;
        e.cs_n = c; e.sclk = s; e.busy = b; e.done = d; e.wr_en = w;
        e.req_err = r; e.ready = rd; e.ferr = f; e.addr = AW'(a); e.data = dt;
        return e;
    endfunction

    function automatic void push_frame(bit wr, int a, logic [15:0] w, bit b, bit rd);
        logic [11:0] dv = (w >> 1) & 12'hFFF;
        repeat (H) q.push_back(mk(0, 1, b, 0, 0, 0, rd, fe_push, 0, 0));
        for (int k = 0; k < 16; k++) begin
            repeat (H) q.push_back(mk(0, 0, b, 0, 0, 0, rd, fe_push, 0, 0));
            repeat (H) q.push_back(mk(0, 1, b, 0, 0, 0, rd, fe_push, 0, 0));
        end
        if (wr && (w[15:13] != 3'b000)) fe_push = 1'b1;
        for (int g = 0; g < 2 * H; g++)
            q.push_back(mk(1, 1, b, 0, wr && g == 0, 0, rd, fe_push, a, dv));
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // cycle-by-cycle comparison against the expected queue
    always @(negedge clk) begin
        if (chk_on) begin
            exp_t e;
            bit bad = 1'b0;
            if (q.size() > 0) begin
                e = q.pop_front();
                last = e;
            end else begin
                e = mk(1, 1, 0, 0, 0, 0, last.ready, last.ferr, 0, 0);
            end
            if (wr_en) wr_seen++;
            n_vec++;
            if (cs_n !== e.cs_n || sclk !== e.sclk) begin
                bad = 1; $display("FAIL R2 cs_n/sclk: actual %b%b expected %b%b", cs_n, sclk, e.cs_n, e.sclk);
            end
            if (busy !== e.busy || done !== e.done) begin
                bad = 1; $display("FAIL R8 busy/done: actual %b%b expected %b%b", busy, done, e.busy, e.done);
            end
            if (wr_en !== e.wr_en || (e.wr_en && wr_addr !== e.addr)) begin
                bad = 1; $display("FAIL R6 wr_en/addr: actual %b/%0d expected %b/%0d", wr_en, wr_addr, e.wr_en, e.addr);
            end
            if (e.wr_en && wr_data !== e.data) begin
                bad = 1; $display("FAIL R3 wr_data: actual %h expected %h", wr_data, e.data);
            end
            if (req_err !== e.req_err) begin
                bad = 1; $display("FAIL R7 req_err: actual %b expected %b", req_err, e.req_err);
            end
            if (ready !== e.ready) begin
                bad = 1; $display("FAIL R5 ready: actual %b expected %b", ready, e.ready);
            end
            if (frame_err !== e.ferr) begin
                bad = 1; $display("FAIL R4 frame_err: actual %b expected %b", frame_err, e.ferr);
            end
            if (bad) n_bad++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_q();
        while (q.size() != 0) tick(1);
        tick(3);
    endtask

    task automatic reset_check();
        check(cs_n === 1'b1 && sclk === 1'b1, "R1", "cs_n/sclk", {cs_n, sclk}, 3);
        check({busy, done, ready, req_err, wr_en} === 5'b0, "R1", "status", {busy, done, ready, req_err, wr_en}, 0);
        check(frame_err === 1'b0, "R1 R4", "frame_err", frame_err, 0);
    endtask

    task automatic pulse_start(int c);
        start = 1'b1; count = CW'(c);
        tick(1);
        start = 1'b0;
    endtask

    task automatic burst(int n);
        tick(1);
        for (int i = 0; i < n; i++) adc_q.push_back(words_q[i]);
        for (int i = 0; i < n; i++) push_frame(1, i, words_q[i], 1, 1);
        q.push_back(mk(1, 1, 0, 1, 0, 0, 1, fe_push, 0, 0));
        pulse_start(n);
    endtask

    task automatic reject(int c);
        tick(1);
        q.push_back(mk(1, 1, 0, 0, 0, 1, 1, fe_push, 0, 0)); // R7
        pulse_start(c);
        wait_q();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        last = mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        tick(3);
        reset_check(); // R1
        rst = 1'b0; chk_on = 1'b1;
        tick(2);
        pulse_start(1); // ignored while disabled (R5)
        tick(4);

        // R5: settle, dummy frame with a bad word that must be discarded
        adc_q.push_back(16'hE5A5);
        repeat (SETTLE) q.push_back(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0));
        push_frame(0, 0, 16'hE5A5, 0, 0);
        q.push_back(mk(1, 1, 0, 0, 0, 0, 1, 0, 0, 0));
        enable = 1'b1;
        tick(30);
        pulse_start(1); // R5: start before ready is ignored
        wait_q();
        check(frame_err === 1'b0, "R5", "dummy frame_err", frame_err, 0);

        // R3: single conversion
        words_q = '{16'h0ABC};
        burst(1);
        wait_q();

        // R7: rejected counts
        reject(0);
        reject(MAXS + 1);
        reject((1 << CW) - 1);

        // R6 R3 R9: burst of four with a stray start while busy
        words_q = '{16'h1FFF, 16'h0001, 16'h1000, 16'h0002};
        wr_seen = 0;
        burst(4);
        tick(100);
        pulse_start(2); // R9
        wait_q();
        check(wr_seen == 4, "R9", "write count", wr_seen, 4);

        // R4 R6: full-length burst, one frame with a bad leading bit
        words_q = '{16'h0123, 16'h1555, 16'h0AAA, 16'h1E01, 16'h0F0F,
                    16'h2000, 16'h0246, 16'h1FFE};
        burst(MAXS);
        wait_q();
        check(frame_err === 1'b1, "R4", "frame_err set", frame_err, 1);

        // R4: good frame leaves the flag set
        words_q = '{16'h0100};
        burst(1);
        wait_q();

        // R10: abort in mid-frame
        words_q = '{16'h0111, 16'h0222, 16'h0333};
        burst(3);
        tick(60);
        enable = 1'b0;
        q.delete();
        adc_q.delete();
        q.push_back(mk(1, 1, 0, 0, 0, 0, 0, fe_push, 0, 0));
        tick(2);
        check(cs_n === 1'b1 && sclk === 1'b1 && busy === 1'b0 && ready === 1'b0,
              "R10", "abort pins", {cs_n, sclk, busy, ready}, 4'b1100);
        check(frame_err === 1'b1, "R4", "kept over disable", frame_err, 1);
        tick(5);

        // R1 R4: reset clears the sticky flag
        chk_on = 1'b0;
        rst = 1'b1;
        tick(2);
        reset_check();
        finish_run();
    end

endmodule